// File: doc/BRIEF.md
# Partial Reconfiguration Freeze Controller

This block keeps one reconfigurable region of the fabric apart from the shared bus while that region is being reprogrammed. Software reaches it through a small 32-bit register slave. A register write asks for a freeze or an unfreeze. The block then runs a request/acknowledge handshake with the isolation logic and reports the result in two sticky completion flags. It also drives a freeze output that gates region traffic and a region reset that can only be raised while the region is fully frozen.

A request that does not fit the current state is dropped and recorded in an error register, which software clears by writing 1. A constant version word lets software check which register layout it is talking to. The isolation muxes and the reconfiguration engine are outside the block. The region's acknowledge arrives on an input.

Top module: `pr_freeze_ctrl`

## Requirements
- R1: After synchronous reset, status reads 2 (unfreeze-done=1, freeze-done=0), control reads 0, the error register reads 0, and `freeze_out`, `freeze_req`, `thaw_req` and `region_rst` are all low.
- R2: The registers are selected by byte address: status at 0, control at 4, error at 8, version at 12. The version register always reads 2. Writes to status or version change nothing.
- R3: A control write with bit 0 set (freeze), accepted from the running state, raises `freeze_req` and `freeze_out` in the next cycle. Status stays 2 until the acknowledge arrives.
- R4: When `region_ack` is high in a cycle where `freeze_req` is high, status becomes 1 (freeze-done=1, unfreeze-done=0) in the next cycle and `freeze_req` drops. `freeze_out` stays high.
- R5: A control write with bit 2 set (unfreeze), accepted from the frozen state, raises `thaw_req` in the next cycle. When `region_ack` is seen with `thaw_req` high, status returns to 2 and `freeze_out` and `thaw_req` go low.
- R6: Error bit 0 is set, and the write has no other effect (control contents and state unchanged), in these cases: a freeze request unless the block is running with no transfer in progress; an unfreeze request unless the block is frozen with no transfer in progress; or both bits 0 and 2 set in one write.
- R7: Writing a value with bit 0 = 1 to the error register clears it. Writing a value with bit 0 = 0 leaves it unchanged.
- R8: `region_rst` equals control bit 1 while the block is frozen (freeze-done set, no unfreeze in progress) and is low in every other state.
- R9: An accepted control write stores bits [2:0], which read back at offset 4. A write of 0, or of the reset bit alone, is accepted in every state and does not change the freeze state.
- R10: `freeze_req` and `thaw_req` are never high together, and the two completion flags are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| region_ack | input | 1 | Acknowledge from the isolation logic |
| freeze_req | output | 1 | Freeze request toward the isolation logic |
| thaw_req | output | 1 | Unfreeze request toward the isolation logic |
| freeze_out | output | 1 | Gates region traffic while high |
| region_rst | output | 1 | Reset for the reconfigurable region |

## Verification
The assertions check the following on every cycle: the two requests are mutually exclusive, the two done flags are exclusive, a request holds until it is acknowledged, an acknowledge moves the flags and the freeze output, a rejected write leaves the control register untouched, the error bit stays sticky, and the region reset is gated to the frozen state. Whether a given control value is legal in a given state, and what reads back afterwards, can only be shown by the bench. It drives every 3-bit control value from each of the four handshake states and compares status, control, error and outputs against a model built from the requirements. It then completes any pending handshake and exercises clearing of the error register.

// File: rtl/pr_freeze_pkg.sv
package pr_freeze_pkg;

    localparam int CSR_DW      = 32;
    localparam int VERSION_NUM = 2;

    // word indices (byte offset / 4)
    localparam int W_STATUS = 0;
    localparam int W_CTRL   = 1;
    localparam int W_ERR    = 2;
    localparam int W_VER    = 3;

    // control bit positions
    localparam int CB_FREEZE = 0;
    localparam int CB_RST    = 1;
    localparam int CB_THAW   = 2;
    localparam int CTRL_W    = 3;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_FREEZING = 2'd1,
        ST_FROZEN   = 2'd2,
        ST_THAWING  = 2'd3
    } iso_state_e;

    typedef struct packed {
        logic frz_done;
        logic thaw_done;
        logic busy;
        logic frozen;
    } iso_stat_s;

    typedef struct packed {
        logic go_freeze;
        logic go_thaw;
        logic bad;
    } iso_cmd_s;

    function automatic iso_cmd_s decode_cmd(input logic want_f,
                                            input logic want_t,
                                            input iso_stat_s st);
        iso_cmd_s c;
        logic ok_f;
        logic ok_t;
        ok_f        = st.thaw_done & ~st.busy;
        ok_t        = st.frz_done & ~st.busy;
        c.bad       = (want_f & want_t) | (want_f & ~ok_f) | (want_t & ~ok_t);
        c.go_freeze = want_f & ~c.bad;
        c.go_thaw   = want_t & ~c.bad;
        return c;
    endfunction

endpackage

// File: rtl/pr_freeze_fsm.sv
module pr_freeze_fsm
    import pr_freeze_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      go_freeze,
    input  logic      go_thaw,
    input  logic      ack,
    output iso_stat_s stat,
    output logic      freeze_req,
    output logic      thaw_req,
    output logic      freeze_out
);

    iso_state_e state_q;
    logic       fdone_q;
    logic       tdone_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            fdone_q <= 1'b0;
            tdone_q <= 1'b1;
        end else begin
            case (state_q)
                ST_RUN: if (go_freeze) state_q <= ST_FREEZING;
                ST_FREEZING: if (ack) begin
                    state_q <= ST_FROZEN;
                    fdone_q <= 1'b1;
                    tdone_q <= 1'b0;
                end
                ST_FROZEN: if (go_thaw) state_q <= ST_THAWING;
                ST_THAWING: if (ack) begin
                    state_q <= ST_RUN;
                    fdone_q <= 1'b0;
                    tdone_q <= 1'b1;
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    always_comb begin
        freeze_req     = (state_q == ST_FREEZING);
        thaw_req       = (state_q == ST_THAWING);
        freeze_out     = (state_q != ST_RUN);
        stat.frz_done  = fdone_q;
        stat.thaw_done = tdone_q;
        stat.busy      = freeze_req | thaw_req;
        stat.frozen    = (state_q == ST_FROZEN);
    end

    p_req_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(freeze_req && thaw_req));
    p_done_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(fdone_q && tdone_q));
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (freeze_req && !ack) |=> freeze_req);
    p_ack_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        (freeze_req && ack) |=> (fdone_q && !tdone_q && freeze_out && !freeze_req));
    p_ack_thaw_r5: assert property (@(posedge clk) disable iff (rst)
        (thaw_req && ack) |=> (tdone_q && !fdone_q && !freeze_out));

endmodule

// File: rtl/pr_freeze_err.sv
module pr_freeze_err (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
    p_err_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

endmodule

// File: rtl/pr_freeze_csr.sv
module pr_freeze_csr
    import pr_freeze_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DW      = CSR_DW,
    parameter int VERSION = VERSION_NUM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  iso_stat_s         stat,
    input  logic              err_flag,
    output logic [DW-1:0]     rdata,
    output logic              go_freeze,
    output logic              go_thaw,
    output logic              bad_req,
    output logic              err_clr,
    output logic              rst_gated
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  widx;
    logic              wr_ctrl;
    logic [CTRL_W-1:0] ctrl_q;
    iso_cmd_s          cmd;

    assign widx    = addr[ADDR_W-1:2];
    assign wr_ctrl = wr && (widx == IDX_W'(W_CTRL));
    assign err_clr = wr && (widx == IDX_W'(W_ERR)) && wdata[0];

    always_comb begin
        cmd       = decode_cmd(wdata[CB_FREEZE], wdata[CB_THAW], stat);
        go_freeze = wr_ctrl & cmd.go_freeze;
        go_thaw   = wr_ctrl & cmd.go_thaw;
        bad_req   = wr_ctrl & cmd.bad;
    end

    always_ff @(posedge clk) begin
        if (rst)                   ctrl_q <= '0;
        else if (wr_ctrl && !cmd.bad) ctrl_q <= wdata[CTRL_W-1:0];
    end

    assign rst_gated = ctrl_q[CB_RST] & stat.frozen;

    always_comb begin
        rdata = '0;
        case (widx)
            IDX_W'(W_STATUS): rdata = DW'({stat.thaw_done, stat.frz_done});
            IDX_W'(W_CTRL):   rdata = DW'(ctrl_q);
            IDX_W'(W_ERR):    rdata = DW'(err_flag);
            IDX_W'(W_VER):    rdata = DW'(VERSION);
            default:          rdata = '0;
        endcase
    end

    logic unused_bits;
    assign unused_bits = &{1'b0, addr[1:0], wdata[DW-1:CTRL_W]};

    p_bad_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        bad_req |=> $stable(ctrl_q));
    p_one_go_r10: assert property (@(posedge clk) disable iff (rst)
        !(go_freeze && go_thaw));

endmodule

// File: rtl/pr_freeze_ctrl.sv
module pr_freeze_ctrl
    import pr_freeze_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int VERSION = VERSION_NUM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              region_ack,
    output logic              freeze_req,
    output logic              thaw_req,
    output logic              freeze_out,
    output logic              region_rst
);

    iso_stat_s stat;
    logic      go_freeze, go_thaw, bad_req, err_clr, err_flag;

    pr_freeze_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .go_freeze  (go_freeze),
        .go_thaw    (go_thaw),
        .ack        (region_ack),
        .stat       (stat),
        .freeze_req (freeze_req),
        .thaw_req   (thaw_req),
        .freeze_out (freeze_out)
    );

    pr_freeze_err u_err (
        .clk  (clk),
        .rst  (rst),
        .set  (bad_req),
        .clr  (err_clr),
        .flag (err_flag)
    );

    pr_freeze_csr #(
        .ADDR_W  (ADDR_W),
        .DW      (32),
        .VERSION (VERSION)
    ) u_csr (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .stat      (stat),
        .err_flag  (err_flag),
        .rdata     (bus_rdata),
        .go_freeze (go_freeze),
        .go_thaw   (go_thaw),
        .bad_req   (bad_req),
        .err_clr   (err_clr),
        .rst_gated (region_rst)
    );

    p_rst_gate_r8: assert property (@(posedge clk) disable iff (rst)
        region_rst |-> (freeze_out && !freeze_req && !thaw_req));
    p_run_open_r1: assert property (@(posedge clk) disable iff (rst)
        !freeze_out |-> (!region_rst && !freeze_req && !thaw_req));

endmodule

// File: tb/pr_freeze_ctrl_test.sv
module pr_freeze_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        region_ack = 1'b0;
    logic        freeze_req, thaw_req, freeze_out, region_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pr_freeze_ctrl uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .region_ack(region_ack),
        .freeze_req(freeze_req), .thaw_req(thaw_req),
        .freeze_out(freeze_out), .region_rst(region_rst)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_ack();
        @(negedge clk); region_ack = 1'b1;
        @(negedge clk); region_ack = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    // state codes: 0 run, 1 freezing, 2 frozen, 3 thawing
    task automatic go_state(input int s);
        do_reset();
        if (s >= 1) wr(4'd4, 32'd1);
        if (s >= 2) pulse_ack();
        if (s == 3) wr(4'd4, 32'd4);
    endtask

    function automatic logic [3:0] outs_for(input int s, input logic rbit);
        return {s != 0, s == 1, s == 3, (s == 2) && rbit};
    endfunction

    task automatic check_all(input string tag, input int s, input logic [2:0] c, input logic e);
        logic [31:0] d;
        rd(4'd0, d); check({tag, " status R3/R4/R5"}, d, {30'd0, (s == 0 || s == 1), (s == 2 || s == 3)});
        rd(4'd4, d); check({tag, " ctrl R9"}, d, {29'd0, c});
        rd(4'd8, d); check({tag, " err R6"}, d, {31'd0, e});
        check({tag, " outputs R8 R10"}, {28'd0, freeze_out, freeze_req, thaw_req, region_rst},
              {28'd0, outs_for(s, c[1])});
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        do_reset();
        // R1 reset state
        check_all("R1 reset", 0, 3'd0, 1'b0);
        // R2 version and read-only words
        rd(4'd12, d); check("R2 version", d, 32'd2);
        wr(4'd0, 32'hFFFF_FFFF); wr(4'd12, 32'h5);
        rd(4'd12, d); check("R2 version after write", d, 32'd2);
        check_all("R2 status write ignored", 0, 3'd0, 1'b0);

        // sweep: every control value from every state
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 8; v++) begin
                logic [2:0] prev, cv;
                logic bad, f, t;
                int ns;
                prev = (s == 0) ? 3'd0 : (s == 3) ? 3'd4 : 3'd1;
                f = v[0]; t = v[2];
                bad = (f && t) || (f && s != 0) || (t && s != 2);
                ns = s;
                if (!bad && f) ns = 1;
                if (!bad && t) ns = 3;
                cv = bad ? prev : 3'(v);
                go_state(s);
                wr(4'd4, 32'(v));
                check_all($sformatf("sweep s%0d v%0d R6 R9", s, v), ns, cv, bad);
                if (ns == 1 || ns == 3) begin
                    // R3 R5: request holds with no acknowledge
                    @(negedge clk); @(negedge clk);
                    check_all($sformatf("hold s%0d v%0d R3", s, v), ns, cv, bad);
                    pulse_ack();
                    ns = (ns == 1) ? 2 : 0;
                    check_all($sformatf("ack s%0d v%0d R4 R5", s, v), ns, cv, bad);
                end
                // R7 write 0 keeps, write 1 clears
                wr(4'd8, 32'd2);
                rd(4'd8, d); check($sformatf("R7 keep s%0d v%0d", s, v), d, {31'd0, bad});
                wr(4'd8, 32'd1);
                rd(4'd8, d); check($sformatf("R7 clear s%0d v%0d", s, v), d, 32'd0);
            end
        end

        // R8 reset bit written alone while frozen, then cleared by zero write
        go_state(2);
        wr(4'd4, 32'd2);
        check_all("R8 rst on", 2, 3'd2, 1'b0);
        wr(4'd4, 32'd0);
        check_all("R9 zero write frozen", 2, 3'd0, 1'b0);
        wr(4'd4, 32'd6);
        check_all("R8 thaw with rst bit", 3, 3'd6, 1'b0);
        pulse_ack();
        check_all("R5 thaw done rst low", 0, 3'd6, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule